// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Missed-Refresh Catch-Up

This block decides when DRAM refresh cycles run on a system bus that several kinds of agent share. A free-running tick counter marks the end of each refresh interval, and every interval owes one refresh. The bus owner is reported on a two-bit input. When nobody holds the bus, a refresh that falls due runs at once. When a native master holds the bus, the block raises a preempt request, keeps it up until the master lets go, and then runs the refresh.

A legacy master cannot be preempted. While it holds the bus, each interval in which it does not pulse its own refresh line is stored as a missed refresh. The store is capped. A sticky overflow flag records any refresh that falls due while the store is already full. When the legacy master releases the bus, the owed refreshes go out as a back-to-back burst of strobes. A refresh that falls due during the burst joins the queue.

The row-address counter, DRAM command timing and arbitration between masters belong to other blocks.

Top module: `rfsh_sched`

## Requirements
- R1: An internal tick falls due once every `INTERVAL_CYC` clock cycles. With the bus idle, each due tick produces exactly one refresh strobe, which rises on the clock edge after the tick.
- R2: `bus_owner` encodes the owner: 2'b00 idle, 2'b01 native (preemptable) master, 2'b10 legacy master, 2'b11 reserved and treated exactly like a legacy master.
- R3: When a refresh is pending while a native master owns the bus, `preempt_req` goes high on the edge at which the refresh falls due. It stays high while the native master keeps the bus and drops on the first edge at which the owner is no longer native.
- R4: A refresh strobe starts only on an edge at which `bus_owner` is idle. After a legacy tenure, the burst starts on the first edge that samples the bus idle, and it contains one strobe per recorded missed interval.
- R5: At most `MISS_CAP` (default 4) refreshes are held pending. Further misses are dropped, so a burst never exceeds `MISS_CAP` strobes.
- R6: A pulse on `legacy_rfsh` while a legacy master owns the bus satisfies the current interval, up to and including the tick cycle, and that interval is then not recorded as missed.
- R7: `miss_ovf` is set when a refresh falls due while `MISS_CAP` refreshes are already pending. It stays set until `ovf_clr` is pulsed, and a new overflow in the same cycle wins over the clear.
- R8: Each refresh strobe is high for exactly `STROBE_CYC` cycles. Consecutive strobes are separated by at least one low cycle.
- R9: A refresh that falls due during a catch-up burst is added to the pending count and issued as an extra strobe.
- R10: A synchronous active-high reset clears all outputs, the pending count and the interval counter. Misses recorded before the reset are not replayed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_owner | input | 2 | Current bus owner code (idle, native, legacy, reserved) |
| legacy_rfsh | input | 1 | Refresh strobe driven by the legacy master itself |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| preempt_req | output | 1 | Request for the native master to release the bus |
| rfsh_strobe | output | 1 | Refresh cycle strobe, `STROBE_CYC` cycles wide |
| miss_ovf | output | 1 | Sticky flag: a refresh was lost to the pending cap |

## Verification
The assertions check on every cycle that strobes start only after the bus was sampled idle, that a strobe lasts more than one cycle, that the pending count stays within its cap, that the preempt request follows native ownership, that the overflow flag stays set until cleared, and that a legacy refresh pulse on a tick prevents the pending count from growing. Only the bench's scenarios can show burst length against tenure length: the sweep covers one to six missed intervals, a legacy master that refreshes for itself, the reserved owner code, a due tick that lands inside a burst, and a reset taken with misses pending. The same holds for the exact preempt latency after a due tick and for the strobe period on an idle bus.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

  typedef enum logic [1:0] {
    OWN_IDLE   = 2'b00,
    OWN_NATIVE = 2'b01,
    OWN_LEGACY = 2'b10,
    OWN_RSVD   = 2'b11
  } owner_e;

  // Reserved code behaves as a non-preemptable master.
  function automatic logic owner_blocks(input owner_e o);
    return (o == OWN_LEGACY) || (o == OWN_RSVD);
  endfunction

endpackage

// File: rtl/rfsh_tick_gen.sv
module rfsh_tick_gen #(
  parameter int INTERVAL_CYC = 990
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int TICK_W = (INTERVAL_CYC > 2) ? $clog2(INTERVAL_CYC) : 1;
  localparam logic [TICK_W-1:0] LAST = TICK_W'(INTERVAL_CYC - 1);

  logic [TICK_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);

  // R1: the counter never runs past the interval end
  a_r1_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);

  // R1: after a tick the interval restarts from zero
  a_r1_wrap: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> (cnt_q == '0));
endmodule

// File: rtl/rfsh_miss_ledger.sv
module rfsh_miss_ledger
  import rfsh_pkg::*;
#(
  parameter int MISS_CAP = 4,
  parameter int PEND_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  owner_e            owner_i,
  input  logic              legacy_rfsh_i,
  input  logic              issue_i,
  input  logic              ovf_clr_i,
  output logic [PEND_W-1:0] pend_o,
  output logic [PEND_W-1:0] pend_nxt_o,
  output logic              ovf_o
);
  localparam logic [PEND_W:0] CAP_X = (PEND_W+1)'(MISS_CAP);

  logic [PEND_W-1:0] pend_q;
  logic              seen_q;
  logic              ovf_q;
  logic              blocking;
  logic              satisfied;
  logic              due_inc;
  logic [PEND_W:0]   sum;
  logic              over;

  always_comb begin
    blocking  = owner_blocks(owner_i);
    satisfied = blocking && (seen_q || legacy_rfsh_i);
    due_inc   = tick_i && !satisfied;
    sum       = {1'b0, pend_q} + {{PEND_W{1'b0}}, due_inc}
              - {{PEND_W{1'b0}}, issue_i};
    over      = (sum > CAP_X);
    pend_nxt_o = over ? PEND_W'(MISS_CAP) : sum[PEND_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      seen_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      pend_q <= pend_nxt_o;
      if (tick_i)                          seen_q <= 1'b0;
      else if (blocking && legacy_rfsh_i)  seen_q <= 1'b1;
      if (over)           ovf_q <= 1'b1;
      else if (ovf_clr_i) ovf_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;
  assign ovf_o  = ovf_q;

  // R5: pending count never exceeds the cap
  a_r5_cap: assert property (@(posedge clk) disable iff (rst)
    pend_q <= PEND_W'(MISS_CAP));

  // R7: flag holds unless a clear arrives
  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovf_q && !ovf_clr_i) |=> ovf_q);

  // R6: a legacy-side refresh on the tick keeps the count from growing
  a_r6_satisfied: assert property (@(posedge clk) disable iff (rst)
    (tick_i && blocking && legacy_rfsh_i && !issue_i) |=> (pend_q == $past(pend_q)));

  // R4: the issue request only comes with work pending
  a_r4_issue_has_work: assert property (@(posedge clk) disable iff (rst)
    issue_i |-> (pend_q != '0));
endmodule

// File: rtl/rfsh_burst_engine.sv
module rfsh_burst_engine
  import rfsh_pkg::*;
#(
  parameter int STROBE_CYC = 2,
  parameter int PEND_W     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  owner_e            owner_i,
  input  logic [PEND_W-1:0] pend_i,
  input  logic [PEND_W-1:0] pend_nxt_i,
  output logic              issue_o,
  output logic              strobe_o,
  output logic              preempt_o
);
  localparam int STRB_W = (STROBE_CYC > 2) ? $clog2(STROBE_CYC) : 1;
  localparam logic [STRB_W-1:0] WIDTH_M1 = STRB_W'(STROBE_CYC - 1);

  logic              strobe_q;
  logic [STRB_W-1:0] left_q;
  logic              preempt_q;

  // A new strobe may start only from a low cycle, so a burst leaves a gap.
  assign issue_o = (owner_i == OWN_IDLE) && (pend_i != '0) && !strobe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q  <= 1'b0;
      left_q    <= '0;
      preempt_q <= 1'b0;
    end else begin
      if (issue_o) begin
        strobe_q <= 1'b1;
        left_q   <= WIDTH_M1;
      end else if (strobe_q) begin
        if (left_q == '0) strobe_q <= 1'b0;
        else              left_q   <= left_q - 1'b1;
      end
      preempt_q <= (owner_i == OWN_NATIVE) && (pend_nxt_i != '0);
    end
  end

  assign strobe_o  = strobe_q;
  assign preempt_o = preempt_q;

  // R4: a strobe starts only from a cycle that sampled the bus idle
  a_r4_start_idle: assert property (@(posedge clk) disable iff (rst)
    $rose(strobe_q) |-> ($past(owner_i) == OWN_IDLE));

  // R3: preempt is raised only against a native owner
  a_r3_native_only: assert property (@(posedge clk) disable iff (rst)
    preempt_q |-> ($past(owner_i) == OWN_NATIVE));

  // R3: preempt never coincides with a strobe start
  a_r3_no_strobe_start: assert property (@(posedge clk) disable iff (rst)
    preempt_q |-> !$rose(strobe_q));

  generate
    if (STROBE_CYC > 1) begin : g_wide
      // R8: a strobe lasts beyond its first cycle
      a_r8_min_width: assert property (@(posedge clk) disable iff (rst)
        $rose(strobe_q) |=> strobe_q);
    end else begin : g_single
      // R8: a one-cycle strobe drops after one cycle
      a_r8_one_cycle: assert property (@(posedge clk) disable iff (rst)
        strobe_q |=> !strobe_q);
    end
  endgenerate
endmodule

// File: rtl/rfsh_sched.sv
module rfsh_sched
  import rfsh_pkg::*;
#(
  parameter int INTERVAL_CYC = 990,
  parameter int MISS_CAP     = 4,
  parameter int STROBE_CYC   = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] bus_owner,
  input  logic       legacy_rfsh,
  input  logic       ovf_clr,
  output logic       preempt_req,
  output logic       rfsh_strobe,
  output logic       miss_ovf
);
  localparam int PEND_W = $clog2(MISS_CAP + 1);

  owner_e            owner;
  logic              tick;
  logic              issue;
  logic [PEND_W-1:0] pend;
  logic [PEND_W-1:0] pend_nxt;

  assign owner = owner_e'(bus_owner);

  rfsh_tick_gen #(
    .INTERVAL_CYC (INTERVAL_CYC)
  ) u_tick (
    .clk    (clk),
    .rst    (rst),
    .tick_o (tick)
  );

  rfsh_miss_ledger #(
    .MISS_CAP (MISS_CAP),
    .PEND_W   (PEND_W)
  ) u_ledger (
    .clk           (clk),
    .rst           (rst),
    .tick_i        (tick),
    .owner_i       (owner),
    .legacy_rfsh_i (legacy_rfsh),
    .issue_i       (issue),
    .ovf_clr_i     (ovf_clr),
    .pend_o        (pend),
    .pend_nxt_o    (pend_nxt),
    .ovf_o         (miss_ovf)
  );

  rfsh_burst_engine #(
    .STROBE_CYC (STROBE_CYC),
    .PEND_W     (PEND_W)
  ) u_engine (
    .clk        (clk),
    .rst        (rst),
    .owner_i    (owner),
    .pend_i     (pend),
    .pend_nxt_i (pend_nxt),
    .issue_o    (issue),
    .strobe_o   (rfsh_strobe),
    .preempt_o  (preempt_req)
  );

  // R10: nothing is driven in the first cycle after reset
  a_r10_quiet_after_reset: assert property (@(posedge clk)
    $fell(rst) |-> (!rfsh_strobe && !preempt_req && !miss_ovf));
endmodule

// File: tb/rfsh_sched_tb_top.sv
module rfsh_sched_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int INTERVAL   = 20;
  localparam int CAP        = 4;
  localparam int STRB       = 2;

  typedef struct packed {
    logic [1:0] own;
    logic [3:0] k;
    logic [4:0] extra;
    logic       rf;
    logic [3:0] exp_n;
    logic       exp_ovf;
  } vec_t;

  // Strobe counts include the single idle refresh that follows the window.
  localparam vec_t VECS [9] = '{
    '{2'b10, 4'd1, 5'd0,  1'b0, 4'd2, 1'b0},  // R4 one miss
    '{2'b10, 4'd3, 5'd0,  1'b0, 4'd4, 1'b0},  // R4 three misses
    '{2'b10, 4'd4, 5'd0,  1'b0, 4'd5, 1'b0},  // R5 exactly at cap
    '{2'b10, 4'd6, 5'd0,  1'b0, 4'd5, 1'b1},  // R5 R7 beyond cap
    '{2'b10, 4'd3, 5'd0,  1'b1, 4'd1, 1'b0},  // R6 self refresh
    '{2'b11, 4'd2, 5'd0,  1'b0, 4'd3, 1'b0},  // R2 reserved code
    '{2'b01, 4'd1, 5'd0,  1'b0, 4'd2, 1'b0},  // R3 native preempt
    '{2'b00, 4'd2, 5'd0,  1'b0, 4'd3, 1'b0},  // R1 idle bus
    '{2'b10, 4'd4, 5'd16, 1'b0, 4'd5, 1'b0}   // R9 tick inside burst
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] bus_owner = 2'b00;
  logic       legacy_rfsh = 1'b0;
  logic       ovf_clr = 1'b0;
  logic       preempt_req;
  logic       rfsh_strobe;
  logic       miss_ovf;

  int n_chk  = 0;
  int n_fail = 0;
  int width_bad = 0;
  int width_seen = 0;
  int run = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rfsh_sched #(
    .INTERVAL_CYC (INTERVAL),
    .MISS_CAP     (CAP),
    .STROBE_CYC   (STRB)
  ) dut_i (
    .clk         (clk),
    .rst         (rst),
    .bus_owner   (bus_owner),
    .legacy_rfsh (legacy_rfsh),
    .ovf_clr     (ovf_clr),
    .preempt_req (preempt_req),
    .rfsh_strobe (rfsh_strobe),
    .miss_ovf    (miss_ovf)
  );

  // R8 pulse width monitor
  always @(negedge clk) begin
    if (rst) run = 0;
    else if (rfsh_strobe) run = run + 1;
    else begin
      if (run != 0) begin
        width_seen = width_seen + 1;
        if (run != STRB) width_bad = width_bad + 1;
      end
      run = 0;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic string vec_tag(input int i);
    case (i)
      0, 1:    return "R4";
      2, 3:    return "R5";
      4:       return "R6";
      5:       return "R2";
      6:       return "R3";
      7:       return "R1";
      default: return "R9";
    endcase
  endfunction

  // Wait for an idle-bus strobe rise; the tick was the edge before it.
  task automatic align();
    logic p;
    p = rfsh_strobe;
    for (int i = 0; i < 3*INTERVAL; i++) begin
      @(negedge clk);
      if (rfsh_strobe && !p) break;
      p = rfsh_strobe;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int gap;
    int rises;
    logic p;

    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 strobe in reset", int'(rfsh_strobe), 0);
    check("R10 preempt in reset", int'(preempt_req), 0);
    check("R10 ovf in reset", int'(miss_ovf), 0);
    rst = 1'b0;

    // R1 idle period between strobes
    align();
    gap = 0;
    p = 1'b1;
    for (int i = 0; i < 3*INTERVAL; i++) begin
      @(negedge clk);
      gap++;
      if (rfsh_strobe && !p) break;
      p = rfsh_strobe;
    end
    check("R1 idle strobe period", gap, INTERVAL);

    // Vector sweep
    for (int v = 0; v < 9; v++) begin
      int total;
      int hold;
      int pre_idx;
      int pre_low;
      logic prev;
      vec_t cv;
      cv = VECS[v];
      align();
      bus_owner = cv.own;
      legacy_rfsh = cv.rf;
      total = INTERVAL*(int'(cv.k)+2) - 2;
      hold = INTERVAL*int'(cv.k) + int'(cv.extra);
      rises = 0;
      prev = 1'b1;
      pre_idx = -1;
      pre_low = -1;
      for (int i = 1; i <= total; i++) begin
        @(negedge clk);
        if (rfsh_strobe && !prev) rises++;
        prev = rfsh_strobe;
        if (pre_idx >= 0 && i == pre_idx + 1) pre_low = int'(!preempt_req);
        if (cv.own == 2'b01 && pre_idx < 0 && preempt_req) begin
          pre_idx = i;
          bus_owner = 2'b00;
        end
        if (i == hold) begin
          bus_owner = 2'b00;
          legacy_rfsh = 1'b0;
        end
      end
      check($sformatf("%s vector %0d strobe count", vec_tag(v), v), rises, int'(cv.exp_n));
      check($sformatf("R7 vector %0d overflow flag", v), int'(miss_ovf), int'(cv.exp_ovf));
      if (cv.own == 2'b01) begin
        check("R3 preempt latency after tick", pre_idx, INTERVAL-1);
        check("R3 preempt drops after release", pre_low, 1);
      end
      if (cv.exp_ovf) begin
        repeat (5) @(negedge clk);
        check("R7 overflow stays set", int'(miss_ovf), 1);
        ovf_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0;
        check("R7 overflow cleared", int'(miss_ovf), 0);
      end
    end

    // R10 reset with misses pending discards them
    align();
    bus_owner = 2'b10;
    repeat (3*INTERVAL) @(negedge clk);
    rst = 1'b1;
    bus_owner = 2'b00;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    rises = 0;
    p = rfsh_strobe;
    for (int i = 0; i < INTERVAL-1; i++) begin
      @(negedge clk);
      if (rfsh_strobe && !p) rises++;
      p = rfsh_strobe;
    end
    check("R10 no replay after reset", rises, 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (rfsh_strobe && !p) rises++;
      p = rfsh_strobe;
    end
    check("R10 first tick after reset", rises, 1);

    repeat (5) @(negedge clk);
    check("R8 pulse width violations", width_bad, 0);
    check("R8 pulses observed", int'(width_seen > 20), 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule